// File: doc/BRIEF.md
# Trace Enable Filter

This block decides, for every instruction address reported as retired, whether program-flow trace is switched on for that instruction. Three conditions are combined. A selectable enable event must be true. An address range filter, built from a parameterized set of range comparators, must permit the address. Optionally, a start/stop latch, set and cleared by single-address matches, must be on.

A control word written through a one-cycle write strobe holds three things. It holds the set of range comparators that take part, whether that set marks regions to include or regions to exclude, and whether the start/stop latch gates tracing. The start/stop latch updates on every valid address whatever the gating bit says. It is brought out as a separate event output for other trace logic. The trace-enable result is registered and changes only when a valid address is presented.

Top module: `trace_filter_unit`

## Requirements
- R1: After reset, trace_en and ss_state are 0 and the control word is 0 (include mode, no comparator selected, start/stop gating off).
- R2: On a clock edge with ctl_we high, the control word is loaded from ctl_wdata and used from the next cycle on. Bit 25 turns start/stop gating on, bit 24 selects exclude (1) or include (0), and bit k (k = 0..NCMP-1) selects comparator k. All other bits are ignored.
- R3: Comparator k matches when lo_bounds[k] <= addr < hi_bounds[k], unsigned, with the high bound excluded.
- R4: In include mode the filter permits an address only when at least one selected comparator matches. With no comparator selected it permits nothing.
- R5: In exclude mode the filter permits an address only when no selected comparator matches. With no comparator selected it permits everything.
- R6: The event selector ev_sel decodes as follows. 7'h6F is always true. 7'h10+k (k < NCMP) gives the match of comparator k, whether or not that comparator is selected. 7'h20 gives the registered start/stop state. Every other code is false.
- R7: On a valid address equal to start_addr the start/stop state is set. On a valid address equal to stop_addr it is cleared, and stop wins when both match. Without a valid address the state holds.
- R8: The start/stop state updates and appears on ss_state the same way whether or not gating is on.
- R9: On each valid address, trace_en is loaded with event AND filter AND (new start/stop state OR NOT gating). The new start/stop state already includes the match on this address. Without a valid address trace_en holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| lo_bounds | input | NCMP*AW | Low bound of each range comparator, comparator k at [k*AW +: AW] |
| hi_bounds | input | NCMP*AW | Exclusive high bound of each range comparator |
| start_addr | input | AW | Address that sets the start/stop state |
| stop_addr | input | AW | Address that clears the start/stop state |
| ev_sel | input | 7 | Enable event selector |
| addr | input | AW | Retired instruction address |
| addr_vld | input | 1 | Address valid strobe |
| trace_en | output | 1 | Registered trace-enable decision |
| ss_state | output | 1 | Start/stop state as an event resource |

## Verification
The bench builds the block with AW = 16 and NCMP = 4. The narrow address lets the tests place ranges near both ends of the address space and step exactly onto each low bound and each excluded high bound. Four comparators are enough to mix selected and unselected ones, in both filter modes. They also let the event decoder pick a comparator that the filter itself ignores.

// File: rtl/trcf_pkg.sv
package trcf_pkg;
  localparam int CTL_W        = 32;
  localparam int CTL_GATE_BIT = 25;
  localparam int CTL_EXCL_BIT = 24;
  localparam int EV_W         = 7;
  localparam logic [EV_W-1:0] EV_ALWAYS = 7'h6F;
  localparam logic [EV_W-1:0] EV_SSTATE = 7'h20;
  localparam logic [2:0]      EV_CMP_HI = 3'b001;
endpackage

// File: rtl/trcf_ctl.sv
module trcf_ctl
  import trcf_pkg::*;
#(
  parameter int NCMP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             gate_en,
  output logic             excl_mode,
  output logic [NCMP-1:0]  cmp_sel
);
  logic ctl_unused;
  assign ctl_unused = ^ctl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en   <= 1'b0;
      excl_mode <= 1'b0;
      cmp_sel   <= '0;
    end else if (ctl_we) begin
      gate_en   <= ctl_wdata[CTL_GATE_BIT];
      excl_mode <= ctl_wdata[CTL_EXCL_BIT];
      cmp_sel   <= ctl_wdata[NCMP-1:0];
    end
  end

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (gate_en == $past(ctl_wdata[CTL_GATE_BIT])) &&
               (excl_mode == $past(ctl_wdata[CTL_EXCL_BIT])) &&
               (cmp_sel == $past(ctl_wdata[NCMP-1:0])));
  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable({gate_en, excl_mode, cmp_sel}));
endmodule

// File: rtl/trcf_range_filter.sv
module trcf_range_filter #(
  parameter int AW   = 32,
  parameter int NCMP = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic [NCMP*AW-1:0] lo_bounds,
  input  logic [NCMP*AW-1:0] hi_bounds,
  input  logic [NCMP-1:0]    cmp_sel,
  input  logic               excl_mode,
  output logic [NCMP-1:0]    cmp_hit,
  output logic               permit
);
  function automatic logic in_range(input logic [AW-1:0] a,
                                    input logic [AW-1:0] lo,
                                    input logic [AW-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign cmp_hit[k] = in_range(addr, lo_bounds[k*AW +: AW], hi_bounds[k*AW +: AW]);
  end

  logic any_sel_hit;
  assign any_sel_hit = |(cmp_hit & cmp_sel);
  assign permit      = excl_mode ? !any_sel_hit : any_sel_hit;
endmodule

// File: rtl/trcf_startstop.sv
module trcf_startstop #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] stop_addr,
  output logic          start_hit,
  output logic          stop_hit,
  output logic          ss_q,
  output logic          ss_next
);
  assign start_hit = addr_vld && (addr == start_addr);
  assign stop_hit  = addr_vld && (addr == stop_addr);

  always_comb begin
    ss_next = ss_q;
    if (stop_hit)       ss_next = 1'b0;
    else if (start_hit) ss_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b0;
    else        ss_q <= ss_next;
  end

  // R7
  ss_stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !ss_q);
  // R7
  ss_start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && !stop_hit) |=> ss_q);
  // R7
  ss_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(ss_q));
endmodule

// File: rtl/trace_filter_unit.sv
module trace_filter_unit
  import trcf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCMP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic [NCMP*AW-1:0] lo_bounds,
  input  logic [NCMP*AW-1:0] hi_bounds,
  input  logic [AW-1:0]      start_addr,
  input  logic [AW-1:0]      stop_addr,
  input  logic [EV_W-1:0]    ev_sel,
  input  logic [AW-1:0]      addr,
  input  logic               addr_vld,
  output logic               trace_en,
  output logic               ss_state
);
  logic            gate_en, excl_mode;
  logic [NCMP-1:0] cmp_sel, cmp_hit;
  logic            filt_permit;
  logic            start_hit, stop_hit, ss_q, ss_next;
  logic            ev_val, en_next;

  trcf_ctl #(.NCMP(NCMP)) ctl_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .gate_en(gate_en), .excl_mode(excl_mode), .cmp_sel(cmp_sel)
  );

  trcf_range_filter #(.AW(AW), .NCMP(NCMP)) filt_i (
    .addr(addr), .lo_bounds(lo_bounds), .hi_bounds(hi_bounds),
    .cmp_sel(cmp_sel), .excl_mode(excl_mode),
    .cmp_hit(cmp_hit), .permit(filt_permit)
  );

  trcf_startstop #(.AW(AW)) ss_i (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr(addr),
    .start_addr(start_addr), .stop_addr(stop_addr),
    .start_hit(start_hit), .stop_hit(stop_hit),
    .ss_q(ss_q), .ss_next(ss_next)
  );

  function automatic logic ev_value(input logic [EV_W-1:0] sel,
                                    input logic [NCMP-1:0] hits,
                                    input logic            ss);
    logic v;
    v = 1'b0;
    if (sel == EV_ALWAYS)      v = 1'b1;
    else if (sel == EV_SSTATE) v = ss;
    else if (sel[EV_W-1:4] == EV_CMP_HI) begin
      for (int k = 0; k < NCMP; k++)
        if (sel[3:0] == 4'(k)) v = hits[k];
    end
    return v;
  endfunction

  assign ev_val  = ev_value(ev_sel, cmp_hit, ss_q);
  assign en_next = ev_val && filt_permit && (ss_next || !gate_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trace_en <= 1'b0;
    else if (addr_vld) trace_en <= en_next;
  end

  assign ss_state = ss_q;

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(trace_en));
  // R4
  incl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !excl_mode && (cmp_sel == '0)) |=> !trace_en);
  // R5
  excl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && excl_mode && (cmp_sel == '0) && (ev_sel == EV_ALWAYS) && !gate_en)
      |=> trace_en);
  // R9
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && gate_en && stop_hit) |=> !trace_en);
  // R8
  ss_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && start_hit && !stop_hit) |=> ss_state);
endmodule

// File: tb/trace_filter_unit_tb_top.sv
`timescale 1ns/1ps
module trace_filter_unit_tb_top;
  localparam int AW   = 16;
  localparam int NCMP = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ctl_we = 1'b0;
  logic [31:0]        ctl_wdata = '0;
  logic [NCMP*AW-1:0] lo_bounds = '0;
  logic [NCMP*AW-1:0] hi_bounds = '0;
  logic [AW-1:0]      start_addr = '0;
  logic [AW-1:0]      stop_addr = '0;
  logic [6:0]         ev_sel = 7'h6F;
  logic [AW-1:0]      addr = '0;
  logic               addr_vld = 1'b0;
  logic               trace_en, ss_state;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  trace_filter_unit #(.AW(AW), .NCMP(NCMP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .lo_bounds(lo_bounds), .hi_bounds(hi_bounds),
    .start_addr(start_addr), .stop_addr(stop_addr), .ev_sel(ev_sel),
    .addr(addr), .addr_vld(addr_vld), .trace_en(trace_en), .ss_state(ss_state)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // control word: gate bit 25, exclude bit 24, select bits [3:0]
  task automatic write_ctl(input logic gate, input logic excl,
                           input logic [3:0] sel, input logic [31:0] junk);
    @(negedge clk);
    ctl_wdata = junk | {6'b0, gate, excl, 20'b0, sel};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    ctl_wdata = '0;
  endtask

  task automatic step(input logic [AW-1:0] a, input logic exp_en,
                      input logic exp_ss, input string tag);
    @(negedge clk);
    addr = a;
    addr_vld = 1'b1;
    @(negedge clk);
    addr_vld = 1'b0;
    check({tag, " trace_en"}, trace_en, exp_en);
    check({tag, " ss_state"}, ss_state, exp_ss);
  endtask

  task automatic t_reset;
    check("R1 reset trace_en", trace_en, 1'b0);
    check("R1 reset ss_state", ss_state, 1'b0);
    // R1: reset control word = include with nothing selected -> no trace
    step(16'h0150, 1'b0, 1'b0, "R1 reset ctl include-empty");
  endtask

  task automatic t_include;
    write_ctl(1'b0, 1'b0, 4'b0011, 32'h0);
    step(16'h00FF, 1'b0, 1'b0, "R3 below low bound");
    step(16'h0100, 1'b1, 1'b0, "R3 at low bound");
    step(16'h01FF, 1'b1, 1'b0, "R3 last inside");
    step(16'h0200, 1'b0, 1'b0, "R3 high bound excluded");
    step(16'h0450, 1'b1, 1'b0, "R4 second selected range");
    step(16'h1500, 1'b0, 1'b0, "R4 unselected range");
    step(16'hFFFE, 1'b0, 1'b0, "R4 unselected top range");
    write_ctl(1'b0, 1'b0, 4'b0000, 32'h0);
    step(16'h0150, 1'b0, 1'b0, "R4 include empty selection");
  endtask

  task automatic t_exclude;
    write_ctl(1'b0, 1'b1, 4'b0101, 32'h0);
    step(16'h0150, 1'b0, 1'b0, "R5 inside excluded 1");
    step(16'h0300, 1'b1, 1'b0, "R5 outside excluded");
    step(16'h1800, 1'b0, 1'b0, "R5 inside excluded 3");
    step(16'h2000, 1'b1, 1'b0, "R5 at high bound");
    step(16'h0450, 1'b1, 1'b0, "R5 unselected range ignored");
    write_ctl(1'b0, 1'b1, 4'b0000, 32'h0);
    step(16'h0150, 1'b1, 1'b0, "R5 exclude empty selection");
  endtask

  task automatic t_ignored_bits;
    // junk in bits 31,20,8,5: must not change include-with-sel-1 behaviour
    write_ctl(1'b0, 1'b0, 4'b0001, 32'h8010_0120);
    step(16'h0150, 1'b1, 1'b0, "R2 junk bits ignored inside");
    step(16'h0450, 1'b0, 1'b0, "R2 junk bits ignored outside");
  endtask

  task automatic t_event;
    write_ctl(1'b0, 1'b1, 4'b0000, 32'h0);
    ev_sel = 7'h00;
    step(16'h0150, 1'b0, 1'b0, "R6 false code");
    ev_sel = 7'h12;
    step(16'h1800, 1'b1, 1'b0, "R6 comparator event hit");
    step(16'h0300, 1'b0, 1'b0, "R6 comparator event miss");
    ev_sel = 7'h20;
    step(16'h0300, 1'b0, 1'b0, "R6 start/stop event low");
    ev_sel = 7'h6F;
  endtask

  task automatic t_startstop;
    start_addr = 16'h3000;
    stop_addr  = 16'h3100;
    write_ctl(1'b1, 1'b1, 4'b0000, 32'h0);
    step(16'h0010, 1'b0, 1'b0, "R9 gated off");
    step(16'h3000, 1'b1, 1'b1, "R7 start sets, traced");
    step(16'h0020, 1'b1, 1'b1, "R7 state holds");
    step(16'h3100, 1'b0, 1'b0, "R7 stop clears, not traced");
    step(16'h3000, 1'b1, 1'b1, "R7 set again");
    start_addr = 16'h3000;
    stop_addr  = 16'h3000;
    step(16'h3000, 1'b0, 1'b0, "R7 stop wins");
  endtask

  task automatic t_ungated;
    start_addr = 16'h3000;
    stop_addr  = 16'h3100;
    write_ctl(1'b0, 1'b1, 4'b0000, 32'h0);
    step(16'h0010, 1'b1, 1'b0, "R8 ungated traces with state off");
    step(16'h3000, 1'b1, 1'b1, "R8 state still sets");
    ev_sel = 7'h20;
    step(16'h0010, 1'b1, 1'b1, "R6 start/stop event high");
    ev_sel = 7'h6F;
    step(16'h3100, 1'b1, 1'b0, "R8 state still clears");
  endtask

  task automatic t_hold;
    step(16'h0010, 1'b1, 1'b0, "R9 prime");
    @(negedge clk);
    ev_sel = 7'h00;
    addr = 16'h3000;
    repeat (3) @(negedge clk);
    check("R9 hold trace_en without valid", trace_en, 1'b1);
    check("R7 hold state without valid", ss_state, 1'b0);
    ev_sel = 7'h6F;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    lo_bounds = {16'h8000, 16'h1000, 16'h0400, 16'h0100};
    hi_bounds = {16'hFFFF, 16'h2000, 16'h0480, 16'h0200};
    start_addr = 16'h3000;
    stop_addr  = 16'h3100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_include();
    t_exclude();
    t_ignored_bits();
    t_event();
    t_startstop();
    t_ungated();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule